// File: doc/BRIEF.md
# DMA Channel Status and Error Control

This block holds the per-channel control and status state of a multi-channel DMA controller. For each channel it stores an enable bit, three interrupt enables and three event flags: half transfer, transfer complete and transfer error. The transfer engine sends one-cycle event pulses. The block latches them into the flags and drives one interrupt line per channel. A transfer error turns the channel off in hardware. The channel cannot be turned on again until software has acknowledged the error.

Software reaches the block through a simple word-addressed register port. Word 0 is a read-only flag register. Word 1 is a write-one-to-clear register. Words 2 onward hold one control register per channel. Any access narrower than a full word is dropped and answered with an error.

Top module: `dma_stat_ctl`

## Requirements
- R1: A one-cycle pulse on `evt_half[c]`, `evt_done[c]` or `evt_err[c]` sets the matching flag of channel c, and the flag is readable from the next cycle on.
- R2: The flag register (word 0) holds channel c in bits 4c+3..4c: bit 4c is the global flag (OR of the three event flags), 4c+1 is complete, 4c+2 is half, 4c+3 is error.
- R3: A word write to the clear register (word 1) with bit 4c+1, 4c+2 or 4c+3 set clears only that flag. Bit 4c clears all three flags of channel c. Zero bits leave flags unchanged.
- R4: If an event sets a flag in the same cycle that a clear write removes it, the flag ends up set.
- R5: A pulse on `evt_err[c]` clears the enable of channel c on the next cycle, and `ch_en[c]` goes low.
- R6: A write that sets the enable of channel c has no effect while the channel's error flag is set. Once the flag is cleared, the same write sets the enable.
- R7: The control register of channel c is word 2+c: bit 0 enable, bit 1 complete interrupt enable, bit 2 half interrupt enable, bit 3 error interrupt enable. `ch_irq[c]` is high exactly when some event flag and its own enable are both set. The global flag alone never raises it.
- R8: An access whose `bus_size` is not 2 (0 is byte, 1 is half-word, 2 is word) changes no state. It gets a response with `bus_rerr` high and read data zero.
- R9: Writes to the flag register are ignored.
- R10: Every request gets exactly one response (`bus_rvalid`) on the cycle after it. For a word read, `bus_rdata` holds the register value from before any same-cycle update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Response valid, one cycle after request |
| bus_rerr | output | 1 | Error response for narrow access |
| bus_rdata | output | 32 | Read data |
| evt_half | input | NUM_CH | Half-transfer event pulses |
| evt_done | input | NUM_CH | Transfer-complete event pulses |
| evt_err | input | NUM_CH | Transfer-error event pulses |
| ch_en | output | NUM_CH | Channel enable state |
| ch_irq | output | NUM_CH | Per-channel interrupt line |

## Verification
The assertions check on every cycle that an error pulse drops the enable, that an enable write during a pending error leaves the channel off, and that an event wins over a clear. They also check that an error flag survives cycles with no matching clear, that each request is answered the next cycle, and that narrow accesses draw an error. Only the bench scenarios can show that the flag register is laid out correctly and that flags from different channels do not disturb each other. The same holds for interrupt masking per flag, for writes to the read-only word leaving it unchanged, and for the full sequence of error, blocked re-enable, clear and successful re-enable.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
    localparam int          DATA_W    = 32;
    localparam logic [1:0]  SZ_WORD   = 2'd2;
    localparam int          FLAG_REG  = 0;
    localparam int          CLR_REG   = 1;
    localparam int          CTRL_BASE = 2;
    // nibble layout shared by flag, clear and control words
    localparam int          NIB_GLOB  = 0;
    localparam int          NIB_DONE  = 1;
    localparam int          NIB_HALF  = 2;
    localparam int          NIB_ERR   = 3;

    typedef struct packed {
        logic en;
        logic ie_done;
        logic ie_half;
        logic ie_err;
        logic f_done;
        logic f_half;
        logic f_err;
    } chan_st_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } rsp_t;
endpackage

// File: rtl/dma_chan_stat.sv
module dma_chan_stat
    import dma_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_half,
    input  logic       evt_done,
    input  logic       evt_err,
    input  logic       ctrl_we,
    input  logic [3:0] ctrl_wbits,
    input  logic [3:0] clr_bits,
    output logic [3:0] flags,
    output logic [3:0] ctrl_bits,
    output logic       en,
    output logic       irq
);
    chan_st_t st_d, st_q;
    logic     clr_all;

    always_comb begin
        st_d    = st_q;
        clr_all = clr_bits[NIB_GLOB];
        // set dominates clear
        st_d.f_done = evt_done | (st_q.f_done & ~(clr_all | clr_bits[NIB_DONE]));
        st_d.f_half = evt_half | (st_q.f_half & ~(clr_all | clr_bits[NIB_HALF]));
        st_d.f_err  = evt_err  | (st_q.f_err  & ~(clr_all | clr_bits[NIB_ERR]));
        if (ctrl_we) begin
            st_d.ie_done = ctrl_wbits[NIB_DONE];
            st_d.ie_half = ctrl_wbits[NIB_HALF];
            st_d.ie_err  = ctrl_wbits[NIB_ERR];
            st_d.en      = ctrl_wbits[0] & ~st_q.f_err;
        end
        if (evt_err) begin
            st_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags     = {st_q.f_err, st_q.f_half, st_q.f_done,
                        st_q.f_err | st_q.f_half | st_q.f_done};
    assign ctrl_bits = {st_q.ie_err, st_q.ie_half, st_q.ie_done, st_q.en};
    assign en        = st_q.en;
    assign irq       = (st_q.f_done & st_q.ie_done) |
                       (st_q.f_half & st_q.ie_half) |
                       (st_q.f_err  & st_q.ie_err);

    assert_err_drops_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err |=> !en);
    assert_en_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && flags[NIB_ERR]) |=> !en);
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done || evt_half) |=> flags[NIB_GLOB]);
    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[NIB_ERR] && !clr_bits[NIB_ERR] && !clr_bits[NIB_GLOB]) |=> flags[NIB_ERR]);
endmodule

// File: rtl/dma_stat_regif.sv
module dma_stat_regif
    import dma_stat_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          size,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [4*NUM_CH-1:0] flag_vec,
    input  logic [4*NUM_CH-1:0] ctrl_vec,
    output logic [NUM_CH-1:0]   ctrl_we,
    output logic [3:0]          ctrl_wbits,
    output logic [4*NUM_CH-1:0] clr_vec,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_data
);
    localparam int NIB_W = 4 * NUM_CH;

    rsp_t              rsp_d, rsp_q;
    logic              ok;
    logic [DATA_W-1:0] rd;

    always_comb begin
        ok         = req && (size == SZ_WORD);
        ctrl_we    = '0;
        clr_vec    = '0;
        ctrl_wbits = wdata[3:0];
        rd         = '0;
        if (ok && wr && addr == ADDR_W'(CLR_REG)) begin
            clr_vec = wdata[NIB_W-1:0];
        end
        if (addr == ADDR_W'(FLAG_REG)) begin
            rd[NIB_W-1:0] = flag_vec;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(CTRL_BASE + c)) begin
                ctrl_we[c] = ok && wr;
                rd[3:0]    = ctrl_vec[4*c +: 4];
            end
        end
        rsp_d.valid = req;
        rsp_d.err   = req && !ok;
        rsp_d.data  = (ok && !wr) ? rd : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_data  = rsp_q.data;

    assert_resp_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);
    assert_narrow_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size != SZ_WORD) |=> (rsp_err && rsp_data == '0));
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);
endmodule

// File: rtl/dma_stat_ctl.sv
module dma_stat_ctl
    import dma_stat_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [1:0]          bus_size,
    input  logic [31:0]         bus_wdata,
    output logic                bus_rvalid,
    output logic                bus_rerr,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_CH-1:0]   evt_half,
    input  logic [NUM_CH-1:0]   evt_done,
    input  logic [NUM_CH-1:0]   evt_err,
    output logic [NUM_CH-1:0]   ch_en,
    output logic [NUM_CH-1:0]   ch_irq
);
    localparam int NIB_W = 4 * NUM_CH;

    logic [NIB_W-1:0]  flag_vec;
    logic [NIB_W-1:0]  ctrl_vec;
    logic [NIB_W-1:0]  clr_vec;
    logic [NUM_CH-1:0] ctrl_we;
    logic [3:0]        ctrl_wbits;

    dma_stat_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (bus_req),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .size       (bus_size),
        .wdata      (bus_wdata),
        .flag_vec   (flag_vec),
        .ctrl_vec   (ctrl_vec),
        .ctrl_we    (ctrl_we),
        .ctrl_wbits (ctrl_wbits),
        .clr_vec    (clr_vec),
        .rsp_valid  (bus_rvalid),
        .rsp_err    (bus_rerr),
        .rsp_data   (bus_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_chan_stat u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_half   (evt_half[c]),
            .evt_done   (evt_done[c]),
            .evt_err    (evt_err[c]),
            .ctrl_we    (ctrl_we[c]),
            .ctrl_wbits (ctrl_wbits),
            .clr_bits   (clr_vec[4*c +: 4]),
            .flags      (flag_vec[4*c +: 4]),
            .ctrl_bits  (ctrl_vec[4*c +: 4]),
            .en         (ch_en[c]),
            .irq        (ch_irq[c])
        );

        assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ch_irq[c] |-> flag_vec[4*c + NIB_GLOB]);
    end
endmodule

// File: tb/sim_dma_stat_ctl.sv
module sim_dma_stat_ctl;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid, bus_rerr;
    logic [31:0] bus_rdata;
    logic [N-1:0] evt_half = '0, evt_done = '0, evt_err = '0;
    logic [N-1:0] ch_en, ch_irq;

    int total = 0;
    int bad   = 0;
    logic [32:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    dma_stat_ctl #(.NUM_CH(N), .ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rerr(bus_rerr), .bus_rdata(bus_rdata),
        .evt_half(evt_half), .evt_done(evt_done), .evt_err(evt_err),
        .ch_en(ch_en), .ch_irq(ch_irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop scoreboard on every response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R10: actual=unexpected response expected=none");
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {31'd0, bus_rerr}, {31'd0, e[32]});
                check(t, bus_rdata, e[31:0]);
            end
        end
    end

    task automatic access(logic wr, logic [3:0] a, logic [1:0] sz,
                          logic [31:0] d, logic err, logic [31:0] exp, string tag);
        exp_q.push_back({err, exp});
        tag_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr32(logic [3:0] a, logic [31:0] d, string tag);
        access(1'b1, a, 2'd2, d, 1'b0, 32'h0, tag);
    endtask

    task automatic rd32(logic [3:0] a, logic [31:0] exp, string tag);
        access(1'b0, a, 2'd2, 32'h0, 1'b0, exp, tag);
    endtask

    task automatic pulse(logic [N-1:0] h, logic [N-1:0] d, logic [N-1:0] e);
        @(negedge clk);
        evt_half = h; evt_done = d; evt_err = e;
        @(negedge clk);
        evt_half = '0; evt_done = '0; evt_err = '0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R5 reset en", {28'd0, ch_en}, 32'd0);
        check("R7 reset irq", {28'd0, ch_irq}, 32'd0);
        rd32(4'd0, 32'h0, "R10 reset flags");

        // channel 0: enable plus all interrupt enables
        wr32(4'd2, 32'hF, "R7 ctrl0 write");
        rd32(4'd2, 32'hF, "R7 ctrl0 readback");
        check("R7 ch_en0", {31'd0, ch_en[0]}, 32'd1);

        pulse(4'b0001, 4'b0000, 4'b0000);
        rd32(4'd0, 32'h5, "R1 R2 half flag ch0");
        check("R7 irq0 half", {31'd0, ch_irq[0]}, 32'd1);

        // channel 1 has no interrupt enables
        pulse(4'b0000, 4'b0010, 4'b0000);
        rd32(4'd0, 32'h35, "R1 R2 done flag ch1");
        check("R7 irq1 masked", {31'd0, ch_irq[1]}, 32'd0);

        wr32(4'd1, 32'h4, "R3 clear half ch0");
        rd32(4'd0, 32'h30, "R3 half cleared");
        check("R7 irq0 after clear", {31'd0, ch_irq[0]}, 32'd0);
        wr32(4'd1, 32'h0, "R3 zero clear");
        rd32(4'd0, 32'h30, "R3 zero clear no effect");

        wr32(4'd0, 32'hFFFF_FFFF, "R9 write flag reg");
        rd32(4'd0, 32'h30, "R9 flag reg unchanged");

        access(1'b1, 4'd3, 2'd0, 32'hF, 1'b1, 32'h0, "R8 byte write");
        access(1'b1, 4'd1, 2'd1, 32'hFFFF, 1'b1, 32'h0, "R8 half clear");
        access(1'b0, 4'd0, 2'd1, 32'h0, 1'b1, 32'h0, "R8 half read");
        rd32(4'd3, 32'h0, "R8 ctrl1 untouched");
        rd32(4'd0, 32'h30, "R8 flags untouched");
        check("R8 ch_en1", {31'd0, ch_en[1]}, 32'd0);

        // set and clear of ch1 done in the same cycle
        exp_q.push_back({1'b0, 32'h0});
        tag_q.push_back("R4 clear write");
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 4'd1; bus_size = 2'd2; bus_wdata = 32'h20;
        evt_done = 4'b0010;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0; evt_done = '0;
        rd32(4'd0, 32'h30, "R4 set wins");

        // error handling on channel 2
        wr32(4'd4, 32'h9, "R7 ctrl2 write");
        check("R7 ch_en2 on", {31'd0, ch_en[2]}, 32'd1);
        pulse(4'b0000, 4'b0000, 4'b0100);
        check("R5 ch_en2 off", {31'd0, ch_en[2]}, 32'd0);
        check("R7 irq2 err", {31'd0, ch_irq[2]}, 32'd1);
        rd32(4'd0, 32'h930, "R1 R2 err flag ch2");
        wr32(4'd4, 32'h9, "R6 re-enable blocked");
        check("R6 ch_en2 still off", {31'd0, ch_en[2]}, 32'd0);
        rd32(4'd4, 32'h8, "R6 ctrl2 readback");
        wr32(4'd1, 32'h100, "R3 global clear ch2");
        rd32(4'd0, 32'h30, "R3 ch2 all cleared");
        check("R7 irq2 cleared", {31'd0, ch_irq[2]}, 32'd0);
        wr32(4'd4, 32'h9, "R6 re-enable allowed");
        check("R6 ch_en2 on", {31'd0, ch_en[2]}, 32'd1);

        wr32(4'd1, 32'h10, "R3 global clear ch1");
        rd32(4'd0, 32'h0, "R3 all flags clear");
        check("R5 ch_en0 kept", {31'd0, ch_en[0]}, 32'd1);

        repeat (2) @(negedge clk);
        check("R10 scoreboard drained", exp_q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule